// File: doc/BRIEF.md
# I2C Block-Transfer Master Engine

This engine performs one complete I2C transaction each time it receives a start strobe. It builds every bus transaction from one START, a sequence of 9-bit byte slots and one STOP. The first byte comes from the transmit byte port and holds the target address and the direction. A write keeps pulling bytes from the same port until it has sent the byte that carries an end flag. A read collects a requested number of bytes and hands each one to a receive port. The engine drives both bus lines as open-drain pull-down enables and samples the resolved line levels back.

Every transaction ends with a one-cycle completion pulse and a 3-bit outcome code. Each failure type has its own code: lost arbitration, a refused address, a refused data byte, and a bus that stays stretched for too long. One input bit selects the SCL rate. The rate is set at the start of each transaction and comes from the system clock frequency parameter.

Top module: `i2c_blk_master`

## Requirements
- R1: The engine pops the first byte on the start strobe, while idle, and sends it first. That byte holds the 7-bit address in bits 7..1. Bit 0 is 1 for a read and 0 for a write.
- R2: A write sends data bytes, each popped only after the previous byte was acknowledged. It stops after the byte whose end flag is set has been acknowledged, and it reports code 0.
- R3: A read with `rd_len` from 1 to 63 receives exactly `rd_len` bytes. It sends each byte, MSB first, on `rx_data` with a one-cycle `rx_push`, and it reports code 0.
- R4: During a read, the engine acknowledges every received byte except the last, which it answers with a NACK (SDA released) before the STOP.
- R5: A NACK on the address byte ends the transaction with a STOP and code 2. No data byte is popped or pushed.
- R6: A NACK on a data byte of a write ends the transaction with a STOP and code 3, even if that byte was the final one. No further byte is popped.
- R7: If SCL stays low for `STRETCH_LIMIT` cycles after the engine has released it, the engine ends with code 4 and releases both lines.
- R8: If SDA reads low while the engine is sending a 1 in an address or write-data bit, the engine releases both lines at once and ends with code 1.
- R9: With `fast` set at the start, the SCL period is 4*floor(CLK_HZ/1.6 MHz) cycles (about 400 kHz). With `fast` clear, it is 4*floor(CLK_HZ/400 kHz) cycles (100 kHz).
- R10: Each completed transaction has exactly one START (SDA falls while SCL is high) and one STOP (SDA rises while SCL is high). At every other time, SDA changes only while SCL is low.
- R11: After reset, both lines are released, `busy` and `done` are low and `result` is 0. At the end of a transaction, `done` is high for exactly one cycle, after the STOP has finished or at an abort.
- R12: A start strobe that arrives while `busy` is high has no effect on the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, taken only while idle |
| fast | input | 1 | 1 selects 400 kHz SCL, 0 selects 100 kHz |
| rd_len | input | 6 | Number of bytes to read (1..63) |
| tx_pop | output | 1 | Pops the current transmit byte |
| tx_data | input | 8 | Byte at the head of the transmit port |
| tx_last | input | 1 | End flag of the head byte |
| rx_push | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte, valid with rx_push |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 lost arbitration, 2 address NACK, 3 data NACK, 4 stretch timeout |

## Verification
The case of interest is a start strobe arriving in the same cycle as an ongoing byte slot. This is provoked by pulsing start a few hundred cycles into a write. The bench judges it by checking that the pop count, the number of START conditions seen on the bus and the outcome code all match a write run without the extra strobe. A second such case is the NACK on the byte that also carries the end flag. There the data-refusal outcome must win over success, and this is checked through the outcome code and the pop count.

// File: rtl/i2c_blk_master.sv
module i2c_blk_master #(
  parameter int CLK_HZ        = 50_000_000,
  parameter int STRETCH_LIMIT = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       fast,
  input  logic [5:0] rd_len,
  output logic       tx_pop,
  input  logic [7:0] tx_data,
  input  logic       tx_last,
  output logic       rx_push,
  output logic [7:0] rx_data,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       busy,
  output logic       done,
  output logic [2:0] result
);
  localparam int Q_SLOW = CLK_HZ / 400_000;
  localparam int Q_FAST = CLK_HZ / 1_600_000;
  localparam int QW = $clog2(Q_SLOW + 1);
  localparam int SW = $clog2(STRETCH_LIMIT + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_XFER, S_STOP} st_t;
  typedef enum logic [1:0] {K_ADDR, K_WR, K_RD} kind_t;

  st_t        st;
  kind_t      kind;
  logic [1:0] ph;
  logic [3:0] bidx;
  logic [7:0] sh;
  logic       smp, rdir, is_last, fast_q, done_q, push_q;
  logic [5:0] left;
  logic [QW-1:0] qcnt;
  logic [SW-1:0] scnt;
  logic [2:0] res;

  wire [QW-1:0] qlast = fast_q ? QW'(Q_FAST - 1) : QW'(Q_SLOW - 1);
  wire txing       = (kind != K_RD);
  wire wait_hi     = (st == S_XFER || st == S_STOP) && ph == 2'd1 && !scl_in;
  wire tick        = !wait_hi && (qcnt == qlast);
  wire stretch_out = wait_hi && (scnt == SW'(STRETCH_LIMIT - 1));
  wire lost        = (st == S_XFER) && ph == 2'd1 && tick && txing && !bidx[3] && sh[7] && !sda_in;
  wire byte_end    = (st == S_XFER) && ph == 2'd3 && tick && bidx[3];
  wire load_wr     = byte_end && !smp && ((kind == K_ADDR && !rdir) || (kind == K_WR && !is_last));

  assign tx_pop  = (st == S_IDLE && start) || load_wr;
  assign rx_push = push_q;
  assign rx_data = sh;
  assign busy    = (st != S_IDLE);
  assign done    = done_q;
  assign result  = res;

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START: begin scl_oe = ph[0]; sda_oe = 1'b1; end
      S_XFER: begin
        scl_oe = (ph == 2'd0) || (ph == 2'd3);
        sda_oe = bidx[3] ? (!txing && left != 6'd1) : (txing && !sh[7]);
      end
      S_STOP: begin scl_oe = (ph == 2'd0); sda_oe = (ph != 2'd2); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_ADDR; ph <= '0; bidx <= '0; sh <= '0;
      smp <= 1'b0; rdir <= 1'b0; is_last <= 1'b0; fast_q <= 1'b0;
      done_q <= 1'b0; push_q <= 1'b0; left <= '0; qcnt <= '0; scnt <= '0; res <= '0;
    end else begin
      done_q <= 1'b0;
      push_q <= 1'b0;
      scnt   <= wait_hi ? scnt + 1'b1 : '0;
      if (st != S_IDLE) qcnt <= tick ? '0 : (wait_hi ? qcnt : qcnt + 1'b1);
      case (st)
        S_IDLE: if (start) begin
          st <= S_START; ph <= '0; qcnt <= '0; fast_q <= fast; left <= rd_len;
          kind <= K_ADDR; sh <= tx_data; rdir <= tx_data[0]; bidx <= '0; res <= '0;
        end
        S_START: if (tick) begin
          if (ph[0]) begin st <= S_XFER; ph <= '0; end
          else ph <= 2'd1;
        end
        S_XFER: begin
          if (stretch_out) begin
            st <= S_IDLE; res <= 3'd4; done_q <= 1'b1;
          end else if (lost) begin
            st <= S_IDLE; res <= 3'd1; done_q <= 1'b1;
          end else if (tick) begin
            ph <= ph + 1'b1;
            if (ph == 2'd1) smp <= sda_in;
            if (ph == 2'd3) begin
              if (!bidx[3]) begin
                sh   <= {sh[6:0], smp};
                bidx <= bidx + 1'b1;
                if (kind == K_RD && bidx == 4'd7) push_q <= 1'b1;
              end else begin
                bidx <= '0;
                if (load_wr) begin
                  sh <= tx_data; is_last <= tx_last; kind <= K_WR;
                end else begin
                  case (kind)
                    K_ADDR: if (smp) begin res <= 3'd2; st <= S_STOP; end
                            else kind <= K_RD;
                    K_WR: begin
                      if (smp) res <= 3'd3;
                      st <= S_STOP;
                    end
                    default: if (left == 6'd1) st <= S_STOP;
                             else left <= left - 1'b1;
                  endcase
                end
              end
            end
          end
        end
        S_STOP: begin
          if (stretch_out) begin
            st <= S_IDLE; res <= 3'd4; done_q <= 1'b1;
          end else if (tick) begin
            if (ph == 2'd2) begin st <= S_IDLE; done_q <= 1'b1; end
            else ph <= ph + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_sda_still_while_scl_up: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && $past(st == S_XFER) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

  a_r8_bus_free_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> (!scl_oe && !sda_oe && done && result == 3'd1));

  a_r7_stretch_code: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(wait_hi)) |-> result == 3'd4);

  a_r1_pop_push_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_pop && rx_push));

  a_r3_push_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (busy && kind == K_RD));

  a_r11_result_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result <= 3'd4);
endmodule

// File: tb/sim_i2c_blk_master.sv
module sim_i2c_blk_master;
  localparam logic [6:0] ADDR7 = 7'h2C;
  localparam int PER_SLOW = 50_000_000 / 100_000;
  localparam int PER_FAST = 4 * (50_000_000 / (4 * 400_000));
  // fields: fast, rd, addr-nack, n[5:0], nack byte[3:0], code[2:0]
  localparam logic [15:0] VEC [0:7] = '{
    {1'b0, 1'b0, 1'b0, 6'd2, 4'd0, 3'd0},
    {1'b1, 1'b0, 1'b0, 6'd3, 4'd0, 3'd0},
    {1'b1, 1'b1, 1'b0, 6'd1, 4'd0, 3'd0},
    {1'b1, 1'b1, 1'b0, 6'd4, 4'd0, 3'd0},
    {1'b1, 1'b0, 1'b1, 6'd2, 4'd0, 3'd2},
    {1'b1, 1'b1, 1'b1, 6'd3, 4'd0, 3'd2},
    {1'b1, 1'b0, 1'b0, 6'd4, 4'd2, 3'd3},
    {1'b1, 1'b0, 1'b0, 6'd1, 4'd1, 3'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, fast = 1'b0;
  logic [5:0] rd_len = '0;
  wire tx_pop, rx_push, scl_oe, sda_oe, busy, done;
  wire [7:0] rx_data;
  wire [2:0] result;

  logic [8:0] txq [0:63];
  logic [5:0] tx_rd = '0;
  wire [7:0] tx_data = txq[tx_rd][7:0];
  wire       tx_last = txq[tx_rd][8];

  logic s_sda_oe = 1'b0, s_scl_hold = 1'b0;
  wire scl_line = !(scl_oe || s_scl_hold);
  wire sda_line = !(sda_oe || s_sda_oe);

  i2c_blk_master #(.CLK_HZ(50_000_000), .STRETCH_LIMIT(2000)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .fast(fast), .rd_len(rd_len),
    .tx_pop(tx_pop), .tx_data(tx_data), .tx_last(tx_last),
    .rx_push(rx_push), .rx_data(rx_data), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done), .result(result));

  always #10 clk = ~clk;

  function automatic logic [7:0] rd_pat(input int k);
    return 8'h5A ^ (8'(k) * 8'd37);
  endfunction
  function automatic logic [7:0] wr_pat(input int k);
    return 8'hC3 + 8'(k * 11);
  endfunction

  logic q_clr = 1'b0, cfg_nack_addr = 1'b0, cfg_arb = 1'b0, cfg_hold = 1'b0;
  logic [5:0] cfg_nack_byte = '0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  logic s_act = 1'b0, first = 1'b0, rd_mode = 1'b0, arb_on = 1'b0, arb_done = 1'b0, hold_done = 1'b0, mack = 1'b0;
  logic [3:0] bitc = '0;
  logic [5:0] bytec = '0;
  logic [7:0] rxsh = '0, txsh = '0, addr_got = '0;
  logic [7:0] wr_log [0:63];
  logic [7:0] rx_log [0:63];
  logic       ack_log [0:63];
  int wn = 0, an = 0, rx_n = 0, n_start = 0, n_stop = 0;
  int cyc = 0, last_rise = -1, min_per = 1_000_000;
  int n_chk = 0, n_err = 0;
  wire [7:0] nxt_pat = rd_pat(int'(bytec) + 1);

  always @(posedge clk) if (q_clr) tx_rd <= '0; else if (tx_pop) tx_rd <= tx_rd + 1'b1;

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    p_scl <= scl_line;
    p_sda <= sda_line;
    if (q_clr) begin
      s_act <= 0; first <= 0; rd_mode <= 0; arb_on <= 0; arb_done <= 0; hold_done <= 0;
      s_sda_oe <= 0; s_scl_hold <= 0; wn <= 0; an <= 0; rx_n <= 0; n_start <= 0; n_stop <= 0;
      min_per <= 1_000_000; last_rise <= -1; addr_got <= '0; bitc <= '0; bytec <= '0;
    end else begin
      if (rx_push && rx_n < 64) begin rx_log[rx_n] <= rx_data; rx_n <= rx_n + 1; end
      if (scl_line && !p_scl) begin
        if (last_rise >= 0 && cyc - last_rise < min_per) min_per <= cyc - last_rise;
        last_rise <= cyc;
      end
      if (!cfg_hold) s_scl_hold <= 1'b0;
      if (!cfg_arb && arb_on) begin s_sda_oe <= 1'b0; arb_on <= 1'b0; end
      if (scl_line && p_scl && p_sda && !sda_line) begin
        s_act <= 1; first <= 1; bitc <= '0; bytec <= '0; rd_mode <= 0; n_start <= n_start + 1;
      end else if (scl_line && p_scl && !p_sda && sda_line) begin
        s_act <= 0; n_stop <= n_stop + 1;
      end else if (s_act && scl_line && !p_scl) begin
        if (!bitc[3]) rxsh <= {rxsh[6:0], sda_line};
        else mack <= sda_line;
      end else if (s_act && !scl_line && p_scl) begin
        if (first) begin
          first <= 0;
          if (cfg_hold && !hold_done) begin s_scl_hold <= 1; hold_done <= 1; end
          if (cfg_arb && !arb_done) begin s_sda_oe <= 1; arb_on <= 1; arb_done <= 1; end
        end else if (bitc == 4'd7) begin
          bitc <= 4'd8;
          if (bytec == 0) begin
            addr_got <= rxsh; rd_mode <= rxsh[0]; s_sda_oe <= !cfg_nack_addr;
          end else if (!rd_mode) begin
            if (wn < 64) wr_log[wn] <= rxsh;
            wn <= wn + 1;
            s_sda_oe <= (bytec != cfg_nack_byte);
          end else s_sda_oe <= 1'b0;
        end else if (bitc == 4'd8) begin
          bitc  <= '0;
          bytec <= bytec + 1'b1;
          if (rd_mode && bytec != 0 && an < 64) begin ack_log[an] <= mack; an <= an + 1; end
          if (rd_mode && !cfg_nack_addr && (bytec == 0 || !mack)) begin
            txsh <= nxt_pat; s_sda_oe <= !nxt_pat[7];
          end else s_sda_oe <= 1'b0;
        end else begin
          bitc <= bitc + 1'b1;
          if (rd_mode && bytec != 0) begin txsh <= {txsh[6:0], 1'b0}; s_sda_oe <= !txsh[6]; end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_xfer(input bit f, input bit rd, input int n, input bit na, input int nb,
                          input int code, input bit arb, input bit hold, input bit poke);
    int exp_pops, mis_a, mis_e;
    bit bad;
    string ctag;
    @(negedge clk);
    q_clr = 1; cfg_nack_addr = na; cfg_nack_byte = 6'(nb); cfg_arb = arb; cfg_hold = hold;
    txq[0] = {1'b0, ADDR7, rd};
    for (int i = 1; i <= n; i++) txq[i] = {(i == n), wr_pat(i)};
    fast = f; rd_len = rd ? 6'(n) : 6'd0;
    @(negedge clk);
    q_clr = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    case (code)
      0: ctag = rd ? "R3" : "R2";
      1: ctag = "R8";
      2: ctag = "R5";
      3: ctag = "R6";
      default: ctag = "R7";
    endcase
    chk(result == 3'(code), ctag, int'(result), code);
    if (code == 1 || code == 4) chk(!scl_oe && !sda_oe, ctag, int'({scl_oe, sda_oe}), 0);
    @(negedge clk);
    chk(!done && !busy, "R11", int'({done, busy}), 0);
    exp_pops = (code == 0 && !rd) ? n + 1 : (code == 3 ? nb + 1 : 1);
    chk(int'(tx_rd) == exp_pops, poke ? "R12" : "R1", int'(tx_rd), exp_pops);
    if (code != 1 && code != 4) begin
      chk(addr_got == {ADDR7, rd}, "R1", int'(addr_got), int'({ADDR7, rd}));
      chk(n_start == 1 && n_stop == 1, "R10", n_start * 10 + n_stop, 11);
      chk(min_per == (f ? PER_FAST : PER_SLOW), "R9", min_per, f ? PER_FAST : PER_SLOW);
    end
    if (code == 0 && !rd) begin
      bad = (wn != n); mis_a = wn; mis_e = n;
      for (int i = 0; i < n && !bad; i++)
        if (wr_log[i] != wr_pat(i + 1)) begin bad = 1; mis_a = int'(wr_log[i]); mis_e = int'(wr_pat(i + 1)); end
      chk(!bad, "R2", mis_a, mis_e);
    end
    if (code == 3) chk(wn == nb, "R6", wn, nb);
    if (code == 2) chk(wn == 0 && rx_n == 0, "R5", wn + rx_n, 0);
    if (code == 0 && rd) begin
      bad = (rx_n != n); mis_a = rx_n; mis_e = n;
      for (int i = 0; i < n && !bad; i++)
        if (rx_log[i] != rd_pat(i + 1)) begin bad = 1; mis_a = int'(rx_log[i]); mis_e = int'(rd_pat(i + 1)); end
      chk(!bad, "R3", mis_a, mis_e);
      bad = (an != n); mis_a = an; mis_e = n;
      for (int i = 0; i < n && !bad; i++)
        if (ack_log[i] != (i == n - 1)) begin bad = 1; mis_a = int'(ack_log[i]); mis_e = int'(i == n - 1); end
      chk(!bad, "R4", mis_a, mis_e);
    end
    cfg_arb = 0; cfg_hold = 0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) txq[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!scl_oe && !sda_oe && !busy && !done && result == 3'd0, "R11",
        int'({scl_oe, sda_oe, busy, done, result}), 0);
    foreach (VEC[i])
      run_xfer(VEC[i][15], VEC[i][14], int'(VEC[i][12:7]), VEC[i][13], int'(VEC[i][6:3]),
               int'(VEC[i][2:0]), 1'b0, 1'b0, 1'b0);
    // R12 start strobe while busy
    run_xfer(1'b1, 1'b0, 3, 1'b0, 0, 0, 1'b0, 1'b0, 1'b1);
    // R8 lost arbitration on address bit
    run_xfer(1'b1, 1'b0, 2, 1'b0, 0, 1, 1'b1, 1'b0, 1'b0);
    // R7 target holds SCL low
    run_xfer(1'b1, 1'b1, 2, 1'b0, 0, 4, 1'b0, 1'b1, 1'b0);
    // R3 longest read
    run_xfer(1'b1, 1'b1, 63, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190_000, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule